// File: doc/BRIEF.md
# Reciprocal Square-Root Seed Unit

This unit turns a single-precision floating-point operand X into a coarse estimate of 1/sqrt(|X|). The estimate is exact to roughly seven or eight mantissa bits, which is enough for two software Newton-Raphson steps of the form Y = Y*(1.5 - Y*Y*X/2) to reach full single-precision accuracy. The operand is taken from an eight-entry register file, and the estimate is written back into the same file.

An operation is issued with a strobe and a 16-bit operation word. Bits 5:3 of that word name the source register and bits 2:0 name the destination. The source is read at the issue edge and the result lands on the following edge. This leaves one delay slot, in which the destination still holds its old value. The result exponent is built by halving the folded biased exponent. A table with 64 entries supplies the mantissa. The table is indexed by the exponent parity and the top five mantissa bits, and each entry is computed at elaboration time from the midpoint of its interval. Special inputs are clamped to finite, non-negative outputs. Two sticky status flags record underflow and overflow events until they are cleared. A separate load port fills the registers and a read port exposes them.

Top module: `rsqrt_est_unit`

## Requirements
- R1: After reset, all eight registers read 0x00000000 and both status flags read 0.
- R2: For an operand whose biased exponent lies in 1..254, the result has sign bit 0 and a biased exponent in 1..254, and it satisfies |Y*sqrt(|X|) - 1| < 2^-6.
- R3: Starting from the result of R2, two steps of Y = Y*(1.5 - Y*Y*|X|/2) give a relative error below 2^-23.
- R4: The sign of the operand is ignored. A negative operand yields exactly the same 32 bits as its magnitude, and bit 31 of every result is 0.
- R5: An operand with biased exponent 0 (a zero or denormal of either sign) yields 0x7F7FFFFF and sets the overflow flag.
- R6: An infinity of either sign yields 0x00000000 and sets the underflow flag. A NaN of either sign yields 0x7F7FFFFF and sets the overflow flag.
- R7: Both flags are sticky. A result of the R2 kind leaves them unchanged, and a flag_clr pulse clears both. If a set and a clear fall on the same edge, the set wins.
- R8: When issue is sampled at edge k, the destination still shows its old value after edge k and shows the result after edge k+1. The operand is read at edge k, so an operation issued in the delay slot that reads that destination sees the old value.
- R9: op_word[5:3] selects the source and op_word[2:0] selects the destination. The bits op_word[15:6] are ignored, and only the destination register is written.
- R10: A new operation can issue on every cycle. Back-to-back operations produce independent, correct results.
- R11: If a load and a result target the same register on the same edge, the result is kept. A load to a different register on that edge also takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Starts an estimate on this edge |
| op_word | input | 16 | Operation word: [5:3] source, [2:0] destination |
| ld_en | input | 1 | Load strobe for the register file |
| ld_sel | input | 3 | Register index to load |
| ld_data | input | 32 | Value to load |
| rd_sel | input | 3 | Register index to read |
| rd_data | output | 32 | Contents of the selected register |
| flag_clr | input | 1 | Clears both sticky flags |
| flag_unf | output | 1 | Sticky underflow flag |
| flag_ovf | output | 1 | Sticky overflow flag |

## Verification
The estimator is fed two groups of ordinary operands. One group consists of exact powers of four and two, which are the table-interval edges where an exponent-halving slip would show. The other group holds values just below a binade boundary and the extreme normals, which separates errors in parity selection from errors in exponent folding. Negative copies of these operands show whether the sign is dropped. Zeros, denormals, infinities and NaNs of both signs check the clamp values and which flag each one sets. Separate sequences cover three cases: back-to-back issues, a delay-slot read of a pending destination, and a load colliding with a writeback. These tell the pipeline timing apart from write-port priority.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

    typedef struct packed {
        logic        sgn;
        logic [7:0]  ex;
        logic [22:0] man;
    } fp32_t;

    typedef enum logic [1:0] {
        CLS_FINITE,
        CLS_ZERO,
        CLS_INF,
        CLS_NAN
    } fcls_t;

    localparam logic [31:0] FP_MAX_POS  = 32'h7F7F_FFFF;
    localparam logic [31:0] FP_POS_ZERO = 32'h0000_0000;
    // 2*127 + 127 - 1: folding constant so that (FOLD - E) >> 1 is the result exponent
    localparam logic [8:0]  EXP_FOLD    = 9'd380;

    function automatic fcls_t fp_classify(input fp32_t v);
        if (v.ex == 8'h00)       return CLS_ZERO;
        else if (v.ex != 8'hFF)  return CLS_FINITE;
        else if (v.man == '0)    return CLS_INF;
        else                     return CLS_NAN;
    endfunction

    // Seed mantissa for table address addr: top bit is exponent parity
    // (1: operand scaled into [1,2), 0: into [2,4)), low idx_w bits pick the
    // mantissa interval; the value is 1/sqrt of the interval midpoint.
    function automatic longint unsigned rsqrt_seed(input int addr, input int idx_w,
                                                   input int frac_w);
        longint unsigned one, den, num, root, trial;
        int k;
        one  = 64'd1;
        k    = frac_w + 8;
        den  = (one << (idx_w + 1)) + 64'(2 * (addr % (1 << idx_w))) + one;
        if (((addr >> idx_w) & 1) == 0)
            den = den << 1;
        num  = (one << (2 * k + idx_w + 1)) / den;
        root = 64'd0;
        for (int b = k; b >= 0; b--) begin
            trial = root | (one << b);
            if (trial * trial <= num)
                root = trial;
        end
        return (root >> (k - 1 - frac_w)) & ((one << frac_w) - one);
    endfunction

endpackage

// File: rtl/rsqrt_lut.sv
module rsqrt_lut
    import rsqrt_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int FRAC_W = 8
) (
    input  logic [IDX_W:0]    addr,
    output logic [FRAC_W-1:0] frac
);
    localparam int DEPTH = 2 ** (IDX_W + 1);

    logic [FRAC_W-1:0] rom [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
        assign rom[gi] = FRAC_W'(rsqrt_seed(gi, IDX_W, FRAC_W));
    end

    assign frac = rom[addr];

endmodule

// File: rtl/rsqrt_core.sv
module rsqrt_core
    import rsqrt_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int FRAC_W = 8
) (
    input  fp32_t x_in,
    output fp32_t y_out,
    output logic  raise_unf,
    output logic  raise_ovf
);
    localparam int PAD_W = 23 - FRAC_W;

    fcls_t             cls;
    logic [IDX_W:0]    lut_addr;
    logic [FRAC_W-1:0] seed_frac;
    logic [8:0]        fold;
    logic              unused_bits;

    assign cls      = fp_classify(x_in);
    // parity of the biased exponent picks the table half
    assign lut_addr = {x_in.ex[0], x_in.man[22 -: IDX_W]};
    assign fold     = EXP_FOLD - {1'b0, x_in.ex};
    assign unused_bits = x_in.sgn ^ fold[0];

    rsqrt_lut #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_lut (
        .addr (lut_addr),
        .frac (seed_frac)
    );

    always_comb begin
        raise_unf = 1'b0;
        raise_ovf = 1'b0;
        y_out     = fp32_t'(FP_MAX_POS);
        case (cls)
            CLS_FINITE: begin
                y_out.sgn = 1'b0;
                y_out.ex  = fold[8:1];
                y_out.man = {seed_frac, {PAD_W{1'b0}}};
            end
            CLS_INF: begin
                y_out     = fp32_t'(FP_POS_ZERO);
                raise_unf = 1'b1;
            end
            default: begin
                y_out     = fp32_t'(FP_MAX_POS);
                raise_ovf = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rsqrt_flags.sv
module rsqrt_flags (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set_unf,
    input  logic set_ovf,
    output logic flag_unf,
    output logic flag_ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_unf <= 1'b0;
            flag_ovf <= 1'b0;
        end else begin
            flag_unf <= set_unf | (flag_unf & ~clr);
            flag_ovf <= set_ovf | (flag_ovf & ~clr);
        end
    end

    AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_unf && !clr) |=> flag_unf); // R7
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_ovf && !clr) |=> flag_ovf); // R7
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_unf && !set_ovf) |=> (!flag_unf && !flag_ovf)); // R7
    AST_OVF_RAISE: assert property (@(posedge clk) disable iff (rst)
        set_ovf |=> flag_ovf); // R5
    AST_UNF_RAISE: assert property (@(posedge clk) disable iff (rst)
        set_unf |=> flag_unf); // R6

endmodule

// File: rtl/rsqrt_regfile.sv
module rsqrt_regfile #(
    parameter int NREG = 8,
    parameter int AW   = $clog2(NREG),
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_idx,
    input  logic [DW-1:0] ld_val,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_idx,
    input  logic [DW-1:0] wb_val,
    input  logic [AW-1:0] ra_idx,
    output logic [DW-1:0] ra_val,
    input  logic [AW-1:0] rb_idx,
    output logic [DW-1:0] rb_val
);
    logic [DW-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[gi] <= '0;
            else if (wb_en && wb_idx == AW'(gi))
                regs[gi] <= wb_val;       // writeback has priority over load
            else if (ld_en && ld_idx == AW'(gi))
                regs[gi] <= ld_val;
        end
    end

    assign ra_val = regs[ra_idx];
    assign rb_val = regs[rb_idx];

endmodule

// File: rtl/rsqrt_est_unit.sv
module rsqrt_est_unit
    import rsqrt_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int IDX_W  = 5,
    parameter int FRAC_W = 8,
    parameter int OP_W   = 16,
    localparam int AW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [OP_W-1:0] op_word,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_sel,
    input  logic [31:0]     ld_data,
    input  logic [AW-1:0]   rd_sel,
    output logic [31:0]     rd_data,
    input  logic            flag_clr,
    output logic            flag_unf,
    output logic            flag_ovf
);
    logic [AW-1:0] src_idx, dst_idx;
    logic [31:0]   src_val;
    logic          unused_op;

    logic          s1_vld;
    logic [AW-1:0] s1_dst;
    fp32_t         s1_x;

    fp32_t         wb_res;
    logic          core_unf, core_ovf;

    assign src_idx   = op_word[2*AW-1:AW];
    assign dst_idx   = op_word[AW-1:0];
    assign unused_op = ^op_word[OP_W-1:2*AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_dst <= '0;
            s1_x   <= '0;
        end else begin
            s1_vld <= issue;
            s1_dst <= dst_idx;
            s1_x   <= fp32_t'(src_val);
        end
    end

    rsqrt_core #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_core (
        .x_in      (s1_x),
        .y_out     (wb_res),
        .raise_unf (core_unf),
        .raise_ovf (core_ovf)
    );

    rsqrt_regfile #(.NREG(NREG), .AW(AW), .DW(32)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_idx (ld_sel),
        .ld_val (ld_data),
        .wb_en  (s1_vld),
        .wb_idx (s1_dst),
        .wb_val (wb_res),
        .ra_idx (src_idx),
        .ra_val (src_val),
        .rb_idx (rd_sel),
        .rb_val (rd_data)
    );

    rsqrt_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .clr      (flag_clr),
        .set_unf  (s1_vld & core_unf),
        .set_ovf  (s1_vld & core_ovf),
        .flag_unf (flag_unf),
        .flag_ovf (flag_ovf)
    );

    AST_NO_NAN: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> (wb_res.ex != 8'hFF)); // R2
    AST_NO_DENORM: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> (wb_res.ex != 8'h00 || wb_res.man == '0)); // R2
    AST_POS_SIGN: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> !wb_res.sgn); // R4
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> !(core_unf && core_ovf)); // R6

endmodule

// File: tb/rsqrt_est_unit_tb.sv
module rsqrt_est_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [15:0] op_word = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        flag_clr = 1'b0;
    logic        flag_unf, flag_ovf;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // model state: 0 none, 1 underflow, 2 overflow
    int cur_cls = 0;
    int pend_q[$];
    bit m_unf = 0, m_ovf = 0;

    always #10 clk = ~clk;

    rsqrt_est_unit dut_i (
        .clk(clk), .rst(rst), .issue(issue), .op_word(op_word),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .flag_clr(flag_clr), .flag_unf(flag_unf), .flag_ovf(flag_ovf)
    );

    function automatic int classify(input logic [31:0] b);
        if (b[30:23] == 8'd0)   return 2;
        if (b[30:23] != 8'hFF)  return 0;
        if (b[22:0] == 23'd0)   return 1;
        return 2;
    endfunction

    function automatic real b2r(input logic [31:0] b);
        real m;
        m = 1.0 + real'(b[22:0]) / 8388608.0;
        return m * $pow(2.0, real'(int'(b[30:23]) - 127));
    endfunction

    // behavioural flag model, evaluated every clock
    always @(posedge clk) begin
        if (rst) begin
            pend_q.delete();
            m_unf = 0;
            m_ovf = 0;
        end else begin
            if (flag_clr) begin
                m_unf = 0;
                m_ovf = 0;
            end
            if (pend_q.size() > 0) begin
                int c;
                c = pend_q.pop_front();
                if (c == 1) m_unf = 1;
                if (c == 2) m_ovf = 1;
            end
            if (issue) pend_q.push_back(cur_cls);
        end
    end

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            nchk++;
            if (flag_unf !== m_unf || flag_ovf !== m_ovf) begin
                nerr++;
                $display("FAIL R7 flags unf/ovf act=%b%b exp=%b%b",
                         flag_unf, flag_ovf, m_unf, m_ovf);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int r, output logic [31:0] v);
        rd_sel = 3'(r);
        #1;
        v = rd_data;
    endtask

    task automatic load(input int r, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1; ld_sel = 3'(r); ld_data = v;
        @(negedge clk);
        ld_en = 0;
    endtask

    // full operation with delay-slot check; returns the written result
    task automatic run_op(input int s, input int d, input logic [31:0] x,
                          input logic [9:0] hi, output logic [31:0] y);
        logic [31:0] old, mid;
        @(negedge clk);
        rd(d, old);
        op_word = {hi, 3'(s), 3'(d)};
        cur_cls = classify(x);
        issue = 1;
        @(negedge clk);
        issue = 0;
        rd(d, mid);
        chk(mid === old, "R8 delay slot keeps old value", mid, old);
        @(negedge clk);
        rd(d, y);
    endtask

    task automatic chk_normal(input logic [31:0] x, input logic [31:0] y);
        real ax, yv, rel, y1, y2, e2;
        ax  = b2r(x);
        yv  = b2r(y);
        rel = yv * $sqrt(ax) - 1.0;
        if (rel < 0.0) rel = -rel;
        nchk++;
        if (y[31] || y[30:23] == 8'd0 || y[30:23] == 8'hFF || rel >= 0.015625) begin
            nerr++;
            $display("FAIL R2 x=%h act=%h (%g) exp~%g", x, y, yv, 1.0 / $sqrt(ax));
        end
        y1 = yv * (1.5 - yv * yv * ax / 2.0);
        y2 = y1 * (1.5 - y1 * y1 * ax / 2.0);
        e2 = y2 * $sqrt(ax) - 1.0;
        if (e2 < 0.0) e2 = -e2;
        nchk++;
        if (e2 >= 1.0 / 8388608.0) begin
            nerr++;
            $display("FAIL R3 x=%h act_err=%g exp_err<%g", x, e2, 1.0 / 8388608.0);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            nerr++; nchk++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    logic [31:0] normals [12] = '{32'h3F80_0000, 32'h4080_0000, 32'h4000_0000,
        32'h3E80_0000, 32'h4040_0000, 32'h3FFF_FF00, 32'h42F6_E979, 32'h0DA2_4260,
        32'h7149_F2CA, 32'h7F7F_FFFF, 32'h0080_0000, 32'h403F_FFF0};

    initial begin
        logic [31:0] y, y2, v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        for (int r = 0; r < 8; r++) begin
            rd(r, v);
            chk(v === 32'h0, "R1 register reset", v, 32'h0);
        end
        chk({flag_unf, flag_ovf} === 2'b00, "R1 flags reset", {30'd0, flag_unf, flag_ovf}, 32'h0);

        // R2 R3 ordinary operands
        foreach (normals[i]) begin
            load(1, normals[i]);
            run_op(1, 2, normals[i], 10'h0, y);
            chk_normal(normals[i], y);
        end
        chk({flag_unf, flag_ovf} === 2'b00, "R7 normals leave flags", {30'd0, flag_unf, flag_ovf}, 32'h0);

        // R4 negative operand gives same bits as magnitude
        load(1, 32'h4080_0000);
        run_op(1, 2, 32'h4080_0000, 10'h0, y);
        load(1, 32'hC080_0000);
        run_op(1, 3, 32'hC080_0000, 10'h0, y2);
        chk(y2 === y && !y2[31], "R4 negative operand", y2, y);
        load(1, 32'hC2F6_E979);
        run_op(1, 3, 32'hC2F6_E979, 10'h0, y2);
        chk(!y2[31], "R4 sign bit zero", y2, {1'b0, y2[30:0]});

        // R5 zeros and denormals
        load(1, 32'h0000_0000);
        run_op(1, 2, 32'h0000_0000, 10'h0, y);
        chk(y === 32'h7F7F_FFFF && flag_ovf, "R5 +0 clamps, ovf set", y, 32'h7F7F_FFFF);
        load(1, 32'h8000_0000);
        run_op(1, 2, 32'h8000_0000, 10'h0, y);
        chk(y === 32'h7F7F_FFFF, "R5 -0 clamps", y, 32'h7F7F_FFFF);
        load(1, 32'h807F_FFFF);
        run_op(1, 2, 32'h807F_FFFF, 10'h0, y);
        chk(y === 32'h7F7F_FFFF, "R5 denormal clamps", y, 32'h7F7F_FFFF);
        chk(!flag_unf, "R5 no underflow from zero", {31'd0, flag_unf}, 32'h0);

        // R7 clear
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        chk({flag_unf, flag_ovf} === 2'b00, "R7 clear", {30'd0, flag_unf, flag_ovf}, 32'h0);

        // R6 infinities and NaNs
        load(1, 32'h7F80_0000);
        run_op(1, 2, 32'h7F80_0000, 10'h0, y);
        chk(y === 32'h0000_0000 && flag_unf && !flag_ovf, "R6 +inf to +0, unf", y, 32'h0);
        load(1, 32'hFF80_0000);
        run_op(1, 2, 32'hFF80_0000, 10'h0, y);
        chk(y === 32'h0000_0000, "R6 -inf to +0", y, 32'h0);
        load(1, 32'h7FC0_0000);
        run_op(1, 2, 32'h7FC0_0000, 10'h0, y);
        chk(y === 32'h7F7F_FFFF && flag_ovf, "R6 NaN clamps, ovf", y, 32'h7F7F_FFFF);
        load(1, 32'hFF81_2345);
        run_op(1, 2, 32'hFF81_2345, 10'h0, y);
        chk(y === 32'h7F7F_FFFF, "R6 negative NaN", y, 32'h7F7F_FFFF);

        // R7 sticky across ordinary op, then set beats clear on the same edge
        load(1, 32'h4000_0000);
        run_op(1, 2, 32'h4000_0000, 10'h0, y);
        chk(flag_unf && flag_ovf, "R7 sticky", {30'd0, flag_unf, flag_ovf}, 32'h3);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        load(1, 32'h0000_0000);
        @(negedge clk);
        op_word = 16'h000A; cur_cls = 2; issue = 1;   // src 1, dst 2
        @(negedge clk);
        issue = 0; flag_clr = 1;                      // clear on the set edge
        @(negedge clk);
        flag_clr = 0;
        chk(flag_ovf, "R7 set wins over clear", {31'd0, flag_ovf}, 32'h1);

        // R8 delay-slot read of the pending destination sees the old value
        load(1, 32'h4080_0000);
        load(3, 32'h0000_0000);
        @(negedge clk);
        op_word = 16'h000B; cur_cls = 0; issue = 1;   // src 1 -> dst 3
        @(negedge clk);
        op_word = 16'h001C; cur_cls = 2;              // src 3 (still zero) -> dst 4
        @(negedge clk);
        issue = 0;
        @(negedge clk);
        rd(4, y);
        chk(y === 32'h7F7F_FFFF, "R8 delay slot reads old source", y, 32'h7F7F_FFFF);
        rd(3, y);
        chk_normal(32'h4080_0000, y);

        // R9 field decode with garbage in upper bits
        load(5, 32'h1234_5678);
        load(6, 32'h4040_0000);
        run_op(6, 7, 32'h4040_0000, 10'h3FF, y);
        chk_normal(32'h4040_0000, y);
        rd(5, v);
        chk(v === 32'h1234_5678, "R9 other register untouched", v, 32'h1234_5678);
        rd(6, v);
        chk(v === 32'h4040_0000, "R9 source untouched", v, 32'h4040_0000);

        // R10 back-to-back issues
        load(0, 32'h4110_0000);  // 9.0
        load(1, 32'h3E80_0000);  // 0.25
        load(2, 32'h7F80_0000);  // +inf
        @(negedge clk);
        op_word = 16'h0005; cur_cls = 0; issue = 1;   // 0 -> 5
        @(negedge clk);
        op_word = 16'h000E; cur_cls = 0;              // 1 -> 6
        @(negedge clk);
        op_word = 16'h0017; cur_cls = 1;              // 2 -> 7
        @(negedge clk);
        issue = 0;
        @(negedge clk);
        rd(5, y); chk_normal(32'h4110_0000, y);
        rd(6, y); chk_normal(32'h3E80_0000, y);
        rd(7, y); chk(y === 32'h0, "R10 third back-to-back result", y, 32'h0);

        // R11 load and writeback collide
        load(1, 32'h4080_0000);
        @(negedge clk);
        op_word = 16'h000C; cur_cls = 0; issue = 1;   // 1 -> 4
        @(negedge clk);
        issue = 0;
        ld_en = 1; ld_sel = 3'd4; ld_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ld_en = 0;
        rd(4, y);
        chk(y !== 32'hDEAD_BEEF, "R11 writeback wins", y, 32'h3F00_0000);
        chk_normal(32'h4080_0000, y);
        @(negedge clk);
        op_word = 16'h000C; cur_cls = 0; issue = 1;
        @(negedge clk);
        issue = 0;
        ld_en = 1; ld_sel = 3'd0; ld_data = 32'hCAFE_F00D;
        @(negedge clk);
        ld_en = 0;
        rd(0, v);
        chk(v === 32'hCAFE_F00D, "R11 load to other register", v, 32'hCAFE_F00D);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule